// File: doc/BRIEF.md
# Stereo Second-Order Recursive Audio Filter

This block filters a stereo audio stream at the codec sample rate. Each time the sample strobe pulses, it captures one 16-bit signed sample per channel and that channel's 2-bit response select. It then runs a second-order Butterworth recursion on each channel and presents one filtered sample per channel together with a single-cycle valid pulse. Samples are read as fractions from -1 up to just below +1.

The four responses are built for a 48 kHz sample rate: straight pass-through, low-pass with its corner at 500 Hz, band-pass spanning 500 Hz to 2 kHz, and high-pass with its corner at 500 Hz. Coefficients are constants with 16 fraction bits and 2 integer bits, one of which is the sign. Each response also carries a power-of-two prescale exponent. It is applied as an arithmetic shift after accumulation, and it applies whenever a response has a coefficient whose magnitude reaches 2.0. The current set needs no prescale, so every exponent is zero. One multiplier is shared by both channels and all taps. The whole computation takes 11 clock cycles after an accepted strobe.

Top module: `stereo_biquad`

## Requirements
- R1: While reset is high and after it is released, out_l and out_r read 0 and out_valid reads 0 until the first result is produced.
- R2: A strobe seen high on a rising edge while the block is idle is accepted. Exactly 11 rising edges later, out_valid is high for exactly one cycle. Each accepted strobe produces exactly one valid pulse.
- R3: Each result is saturated to the range -32768 to 32767 and never wraps.
- R4: Select code 0 is pass-through. Its taps (b0,b1,b2,f1,f2) are (65536,0,0,0,0), so the output equals the input sample bit for bit.
- R5: Each channel computes acc = b0*x + b1*x1 + b2*x2 + f1*y1 + f2*y2 at full precision. Here x1 and x2 are the two previous inputs, and y1 and y2 are the two previous saturated outputs. The result is (acc + 2^15) shifted right arithmetically by 16, then saturated. Select code 1 is low-pass, with taps (67,134,67,125010,-59742).
- R6: Select code 2 is band-pass, with taps (5844,0,-5844,118363,-53849). It uses the same equation as R5.
- R7: Select code 3 is high-pass, with taps (62572,-125144,62572,125010,-59742). It uses the same equation as R5.
- R8: The left and right channels use identical arithmetic. Each channel follows only its own select input and its own sample history.
- R9: When a channel's select at an accepted strobe differs from the select used for its previous sample, that channel's four history values are cleared to zero before the new sample is computed. Reset also clears them, and reset sets the remembered select to code 0.
- R10: A strobe that arrives while a computation is in progress is ignored. Its samples and selects affect neither the pending result nor any later result.
- R11: out_l and out_r change only on the edge that raises out_valid and hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe, one pulse per codec sample period |
| in_l | input | 16 | Left input sample, two's complement |
| in_r | input | 16 | Right input sample, two's complement |
| sel_l | input | 2 | Left response select (0 pass, 1 low, 2 band, 3 high) |
| sel_r | input | 2 | Right response select (0 pass, 1 low, 2 band, 3 high) |
| out_l | output | 16 | Left filtered sample |
| out_r | output | 16 | Right filtered sample |
| out_valid | output | 1 | One-cycle pulse when both results are updated |

## Verification
A corrupted history value or a wrong coefficient fetch shows at the ports on the very next valid pulse, 11 cycles after the following strobe. Because the filter is recursive, the error then persists in later samples until a select change or a reset clears the history. Sequencer faults, such as a skipped tap or a strobe accepted while busy, show within one sample period as a valid pulse at the wrong cycle or as a result that mixes two samples. The reference model computes every result from the stated tap values and is compared against the ports on every clock. This catches both kinds of fault in the cycle they appear.

// File: rtl/sbq_pkg.sv
package sbq_pkg;

  localparam int PKG_SMP_W  = 16;
  localparam int PKG_COEF_W = 18;
  localparam int PKG_FRAC   = 16;
  localparam int NCH        = 2;
  localparam int NTAP       = 5;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_LOW  = 2'd1,
    MODE_BAND = 2'd2,
    MODE_HIGH = 2'd3
  } resp_e;

  // tap order: current input, two past inputs, two past outputs
  typedef enum logic [2:0] {
    TAP_X0 = 3'd0,
    TAP_X1 = 3'd1,
    TAP_X2 = 3'd2,
    TAP_Y1 = 3'd3,
    TAP_Y2 = 3'd4
  } tap_e;

  // Feedback taps are stored already negated so every term is added.
  function automatic int coef_of(resp_e m, tap_e t);
    int v;
    v = 0;
    case (m)
      MODE_PASS: v = (t == TAP_X0) ? 65536 : 0;
      MODE_LOW: begin
        case (t)
          TAP_X0:  v = 67;
          TAP_X1:  v = 134;
          TAP_X2:  v = 67;
          TAP_Y1:  v = 125010;
          TAP_Y2:  v = -59742;
          default: v = 0;
        endcase
      end
      MODE_BAND: begin
        case (t)
          TAP_X0:  v = 5844;
          TAP_X1:  v = 0;
          TAP_X2:  v = -5844;
          TAP_Y1:  v = 118363;
          TAP_Y2:  v = -53849;
          default: v = 0;
        endcase
      end
      MODE_HIGH: begin
        case (t)
          TAP_X0:  v = 62572;
          TAP_X1:  v = -125144;
          TAP_X2:  v = 62572;
          TAP_Y1:  v = 125010;
          TAP_Y2:  v = -59742;
          default: v = 0;
        endcase
      end
      default: v = 0;
    endcase
    return v;
  endfunction

  // Power-of-two prescale exponent per response; nonzero only when a tap
  // magnitude would reach 2.0 in the stored format.
  function automatic int unsigned shift_of(resp_e m);
    case (m)
      MODE_PASS: return 0;
      MODE_LOW:  return 0;
      MODE_BAND: return 0;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/sbq_sequencer.sv
module sbq_sequencer #(
  parameter int NCH  = 2,
  parameter int NTAP = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       stb,
  output logic                       busy,
  output logic                       accept,
  output logic                       mac_en,
  output logic                       first,
  output logic                       fin,
  output logic                       done,
  output logic [$clog2(NCH+1)-1:0]   ch,
  output logic [$clog2(NTAP)-1:0]    tap
);

  localparam int CNT_W = $clog2(NCH+1);
  localparam int TAP_W = $clog2(NTAP);
  localparam logic [CNT_W-1:0] LAST_CH  = CNT_W'(NCH);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NTAP-1);

  assign accept = stb && !busy;
  assign mac_en = busy && (ch != LAST_CH);
  assign first  = mac_en && (tap == '0);
  assign fin    = busy && (tap == '0) && (ch != '0);
  assign done   = busy && (ch == LAST_CH);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ch   <= '0;
      tap  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      ch   <= '0;
      tap  <= '0;
    end else if (busy) begin
      if (ch == LAST_CH) begin
        busy <= 1'b0;
      end else if (tap == LAST_TAP) begin
        tap <= '0;
        ch  <= ch + 1'b1;
      end else begin
        tap <= tap + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbq_mac.sv
module sbq_mac #(
  parameter int A_W   = 16,
  parameter int B_W   = 18,
  parameter int ACC_W = 38
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    first,
  input  logic signed [A_W-1:0]   a,
  input  logic signed [B_W-1:0]   b,
  output logic signed [ACC_W-1:0] acc
);

  localparam int P_W = A_W + B_W;

  logic signed [P_W-1:0]   prod;
  logic signed [ACC_W-1:0] prod_ext;

  assign prod     = a * b;
  assign prod_ext = {{(ACC_W-P_W){prod[P_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (en) begin
      acc <= (first ? '0 : acc) + prod_ext;
    end
  end

endmodule

// File: rtl/sbq_history.sv
module sbq_history #(
  parameter int SMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    push,
  input  logic signed [SMP_W-1:0] x_in,
  input  logic signed [SMP_W-1:0] y_in,
  output logic signed [SMP_W-1:0] x1,
  output logic signed [SMP_W-1:0] x2,
  output logic signed [SMP_W-1:0] y1,
  output logic signed [SMP_W-1:0] y2
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      x1 <= '0;
      x2 <= '0;
      y1 <= '0;
      y2 <= '0;
    end else if (push) begin
      x1 <= x_in;
      x2 <= x1;
      y1 <= y_in;
      y2 <= y1;
    end
  end

endmodule

// File: rtl/stereo_biquad.sv
module stereo_biquad
  import sbq_pkg::*;
#(
  parameter int SMP_W     = PKG_SMP_W,
  parameter int COEF_W    = PKG_COEF_W,
  parameter int COEF_FRAC = PKG_FRAC,
  parameter int GUARD_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_stb,
  input  logic signed [SMP_W-1:0] in_l,
  input  logic signed [SMP_W-1:0] in_r,
  input  logic [1:0]              sel_l,
  input  logic [1:0]              sel_r,
  output logic signed [SMP_W-1:0] out_l,
  output logic signed [SMP_W-1:0] out_r,
  output logic                    out_valid
);

  localparam int ACC_W = SMP_W + COEF_W + GUARD_W;
  localparam int CNT_W = $clog2(NCH+1);
  localparam int TAP_W = $clog2(NTAP);
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic signed [ACC_W-1:0] YMAX = ACC_W'(2**(SMP_W-1) - 1);
  localparam logic signed [ACC_W-1:0] YMIN = -(ACC_W'(2**(SMP_W-1)));

  // channel-indexed views of the ports
  logic signed [SMP_W-1:0] in_v  [NCH];
  logic [1:0]              sel_v [NCH];

  always_comb begin
    in_v[0]  = in_l;
    in_v[1]  = in_r;
    sel_v[0] = sel_l;
    sel_v[1] = sel_r;
  end

  // sequencer
  logic             seq_busy, seq_accept, seq_mac_en, seq_first;
  logic             seq_fin, seq_done;
  logic [CNT_W-1:0] seq_ch;
  logic [TAP_W-1:0] seq_tap;

  sbq_sequencer #(.NCH(NCH), .NTAP(NTAP)) i_seq (
    .clk    (clk),
    .rst    (rst),
    .stb    (smp_stb),
    .busy   (seq_busy),
    .accept (seq_accept),
    .mac_en (seq_mac_en),
    .first  (seq_first),
    .fin    (seq_fin),
    .done   (seq_done),
    .ch     (seq_ch),
    .tap    (seq_tap)
  );

  // per-channel state
  logic signed [SMP_W-1:0] x_cur    [NCH];
  resp_e                   mode_cur [NCH];
  logic signed [SMP_W-1:0] h_x1     [NCH];
  logic signed [SMP_W-1:0] h_x2     [NCH];
  logic signed [SMP_W-1:0] h_y1     [NCH];
  logic signed [SMP_W-1:0] h_y2     [NCH];
  logic signed [SMP_W-1:0] y_next   [NCH];

  logic signed [ACC_W-1:0] acc;
  logic signed [SMP_W-1:0] y_round;
  logic [CH_W-1:0]         mch;
  logic [CH_W-1:0]         fch;
  logic [CNT_W-1:0]        fin_full;

  // operand selection for the shared multiplier
  logic signed [SMP_W-1:0]  op_s;
  logic signed [COEF_W-1:0] op_c;

  always_comb begin
    mch = seq_ch[CH_W-1:0];
    case (tap_e'(seq_tap))
      TAP_X0:  op_s = x_cur[mch];
      TAP_X1:  op_s = h_x1[mch];
      TAP_X2:  op_s = h_x2[mch];
      TAP_Y1:  op_s = h_y1[mch];
      TAP_Y2:  op_s = h_y2[mch];
      default: op_s = '0;
    endcase
    op_c = COEF_W'(coef_of(mode_cur[mch], tap_e'(seq_tap)));
  end

  sbq_mac #(.A_W(SMP_W), .B_W(COEF_W), .ACC_W(ACC_W)) i_mac (
    .clk   (clk),
    .rst   (rst),
    .en    (seq_mac_en),
    .first (seq_first),
    .a     (op_s),
    .b     (op_c),
    .acc   (acc)
  );

  // rounding, prescale compensation and saturation of a finished channel
  int unsigned             sh;
  logic signed [ACC_W-1:0] half;
  logic signed [ACC_W-1:0] biased;
  logic signed [ACC_W-1:0] rnd;

  always_comb begin
    fin_full = seq_ch - 1'b1;
    fch      = fin_full[CH_W-1:0];
    sh       = shift_of(mode_cur[fch]);
    half     = ACC_W'(1) << (COEF_FRAC + sh - 1);
    biased   = acc + half;
    rnd      = biased >>> (COEF_FRAC + sh);
    if (rnd > YMAX) begin
      y_round = YMAX[SMP_W-1:0];
    end else if (rnd < YMIN) begin
      y_round = YMIN[SMP_W-1:0];
    end else begin
      y_round = rnd[SMP_W-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [SMP_W-1:0] x_q;
    resp_e                   mode_q;
    logic signed [SMP_W-1:0] y_hold;
    logic                    clr;
    logic                    push;

    assign clr  = seq_accept && (resp_e'(sel_v[c]) != mode_q);
    assign push = seq_fin && (fch == CH_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        x_q    <= '0;
        mode_q <= MODE_PASS;
      end else if (seq_accept) begin
        x_q    <= in_v[c];
        mode_q <= resp_e'(sel_v[c]);
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        y_hold <= '0;
      end else if (push) begin
        y_hold <= y_round;
      end
    end

    sbq_history #(.SMP_W(SMP_W)) i_hist (
      .clk   (clk),
      .rst   (rst),
      .clear (clr),
      .push  (push),
      .x_in  (x_q),
      .y_in  (y_round),
      .x1    (h_x1[c]),
      .x2    (h_x2[c]),
      .y1    (h_y1[c]),
      .y2    (h_y2[c])
    );

    assign x_cur[c]    = x_q;
    assign mode_cur[c] = mode_q;
    assign y_next[c]   = push ? y_round : y_hold;
  end

  // registered outputs, updated together
  always_ff @(posedge clk) begin
    if (rst) begin
      out_l     <= '0;
      out_r     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= seq_done;
      if (seq_done) begin
        out_l <= y_next[0];
        out_r <= y_next[1];
      end
    end
  end

endmodule

// File: rtl/sbq_checker.sv
module sbq_checker #(
  parameter int SMP_W = 16,
  parameter int LAT   = 11
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    stb,
  input logic                    busy,
  input logic                    out_valid,
  input logic signed [SMP_W-1:0] out_l,
  input logic signed [SMP_W-1:0] out_r,
  input logic signed [SMP_W-1:0] x_l,
  input logic signed [SMP_W-1:0] x_r,
  input logic [1:0]              mode_l,
  input logic [1:0]              mode_r
);

  localparam logic [7:0] DUE = 8'(LAT + 1);

  logic [7:0] since;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
    end else if (stb && !busy) begin
      since <= 8'd1;
    end else if (since == DUE) begin
      since <= '0;
    end else if (since != '0) begin
      since <= since + 8'd1;
    end
  end

  // R2: single-cycle pulse at the fixed latency
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  p_valid_late_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> since == DUE);
  p_valid_due_r2: assert property (@(posedge clk) disable iff (rst)
    since == DUE |-> out_valid);

  // R11: outputs move only with the valid pulse
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_l) && $stable(out_r)));

  // R4: pass-through returns the captured sample
  p_bypass_l_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_l == 2'd0) |-> out_l == x_l);
  p_bypass_r_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_r == 2'd0) |-> out_r == x_r);

  // R10: a strobe during a computation leaves the captured operands alone
  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (stb && busy) |=> ($stable(x_l) && $stable(x_r) &&
                       $stable(mode_l) && $stable(mode_r)));

endmodule

bind stereo_biquad sbq_checker #(
  .SMP_W (SMP_W),
  .LAT   (sbq_pkg::NCH * sbq_pkg::NTAP + 1)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .stb       (smp_stb),
  .busy      (seq_busy),
  .out_valid (out_valid),
  .out_l     (out_l),
  .out_r     (out_r),
  .x_l       (x_cur[0]),
  .x_r       (x_cur[1]),
  .mode_l    (mode_cur[0]),
  .mode_r    (mode_cur[1])
);

// File: tb/test_stereo_biquad.sv
module test_stereo_biquad;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 11;
  localparam int GAP        = 13;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               smp_stb = 1'b0;
  logic signed [15:0] in_l = '0;
  logic signed [15:0] in_r = '0;
  logic [1:0]         sel_l = '0;
  logic [1:0]         sel_r = '0;
  logic signed [15:0] out_l;
  logic signed [15:0] out_r;
  logic               out_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_biquad i_stereo_biquad (
    .clk       (clk),
    .rst       (rst),
    .smp_stb   (smp_stb),
    .in_l      (in_l),
    .in_r      (in_r),
    .sel_l     (sel_l),
    .sel_r     (sel_r),
    .out_l     (out_l),
    .out_r     (out_r),
    .out_valid (out_valid)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // tap values per select code, from the requirements (R4..R7)
  int coef [4][5] = '{
    '{65536,      0,     0,      0,      0},
    '{   67,    134,    67, 125010, -59742},
    '{ 5844,      0, -5844, 118363, -53849},
    '{62572, -125144, 62572, 125010, -59742}
  };

  // reference model state
  int    mx1 [2];
  int    mx2 [2];
  int    my1 [2];
  int    my2 [2];
  int    mmode [2];
  int    pend;
  int    nxt [2];
  int    exp_l, exp_r;
  bit    exp_v;
  string cur_tag = "R2";
  string pend_tag, exp_tag;
  int    sat_hits = 0;
  int    n_valid = 0;
  int    n_sent = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic int model_step(int c, int x, int m);
    longint acc;
    longint y;
    if (m != mmode[c]) begin   // R9 history clear on select change
      mx1[c] = 0; mx2[c] = 0; my1[c] = 0; my2[c] = 0;
      mmode[c] = m;
    end
    acc = longint'(coef[m][0]) * x + longint'(coef[m][1]) * mx1[c]
        + longint'(coef[m][2]) * mx2[c] + longint'(coef[m][3]) * my1[c]
        + longint'(coef[m][4]) * my2[c];
    y = (acc + 64'sd32768) >>> 16;
    if (y > 32767) begin
      y = 32767; sat_hits++;
    end else if (y < -32768) begin
      y = -32768; sat_hits++;
    end
    mx2[c] = mx1[c]; mx1[c] = x;
    my2[c] = my1[c]; my1[c] = int'(y);
    return int'(y);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      pend = 0; exp_v = 0; exp_l = 0; exp_r = 0; exp_tag = "R1";
      for (int c = 0; c < 2; c++) begin
        mx1[c] = 0; mx2[c] = 0; my1[c] = 0; my2[c] = 0; mmode[c] = 0;
      end
    end else begin
      exp_v = 0;
      if (pend > 0) begin
        pend--;                       // strobes here are ignored (R10)
        if (pend == 0) begin
          exp_v = 1; exp_l = nxt[0]; exp_r = nxt[1]; exp_tag = pend_tag;
        end
      end else if (smp_stb) begin
        nxt[0] = model_step(0, int'(in_l), int'(sel_l));
        nxt[1] = model_step(1, int'(in_r), int'(sel_r));
        pend = LAT;
        pend_tag = cur_tag;
      end
    end
  end

  task automatic check(string tag, string what, int act, int expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      string otag;
      check("R2", "out_valid", int'(out_valid), int'(exp_v));
      if (out_valid) n_valid++;
      otag = exp_v ? exp_tag : "R11";
      check(otag, "out_l", int'(out_l), exp_l);
      check(otag, "out_r", int'(out_r), exp_r);
    end
  end

  function automatic int rnd16(int amp_shift);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[30:15])) >>> amp_shift;
  endfunction

  task automatic send(int l, int r, int ml, int mr);
    @(negedge clk);
    in_l = 16'(l); in_r = 16'(r); sel_l = 2'(ml); sel_r = 2'(mr);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    n_sent++;
    repeat (GAP - 2) @(negedge clk);
  endtask

  // accepted strobe followed by a second strobe while busy (R10)
  task automatic send_with_intruder(int l, int r, int ml, int mr);
    @(negedge clk);
    in_l = 16'(l); in_r = 16'(r); sel_l = 2'(ml); sel_r = 2'(mr);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    n_sent++;
    repeat (3) @(negedge clk);
    in_l = 16'(-l); in_r = 16'(12345); sel_l = 2'(ml ^ 1); sel_r = 2'(mr ^ 2);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    repeat (GAP - 6) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not complete got 1 expected 0");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "out_l in reset", int'(out_l), 0);
    check("R1", "out_r in reset", int'(out_r), 0);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);

    // R4: pass-through, including extremes
    cur_tag = "R4";
    send(32767, -32768, 0, 0);
    send(-32768, 32767, 0, 0);
    send(0, -1, 0, 0);
    for (int k = 0; k < 30; k++) send(rnd16(0), rnd16(0), 0, 0);

    // R5 R7 R8: low-pass left, high-pass right on independent streams
    cur_tag = "R5 R7 R8";
    for (int k = 0; k < 120; k++) send(rnd16(1), rnd16(2), 1, 3);

    // R6: band-pass both channels
    cur_tag = "R6";
    for (int k = 0; k < 120; k++) send(rnd16(1), rnd16(3), 2, 2);

    // R3: full-scale square wave into high-pass drives saturation
    cur_tag = "R3";
    for (int rep = 0; rep < 2; rep++) begin
      for (int k = 0; k < 25; k++) send(-32768, 32767, 3, 3);
      for (int k = 0; k < 25; k++) send(32767, -32768, 3, 3);
    end

    // R9: select changes on every sample clear the history
    cur_tag = "R9";
    for (int k = 0; k < 40; k++) send(rnd16(1), rnd16(1), k % 4, (k + 1) % 4);

    // R10: intruding strobes while busy
    cur_tag = "R10";
    for (int k = 0; k < 20; k++) send_with_intruder(rnd16(2), rnd16(2), 1, 2);

    repeat (2 * GAP) @(negedge clk);
    check("R3", "saturation events seen", int'(sat_hits > 0), 1);
    check("R10", "valid pulses versus accepted strobes", n_valid, n_sent);
    finish_run();
  end

endmodule